// File: doc/BRIEF.md
# Circular Branch Trace Recorder

The recorder keeps a rolling history of retired branches in a small ring of 64-bit trace records. Each accepted retire event stores a branch-source record (bundle address, slot of the first taken branch, mispredict flag) and, in the following ring position, a record for the target bundle. The target bundle may itself hold a qualified branch. A build parameter then selects one of two ways to log it. In the merged mode, the record after the source is written as a branch-source record for the target bundle. In the split mode, a plain target record is written and then a third source record for the target bundle.

A write-pointer/wrap register tracks the ring. It holds the next position to write (`bbi`, bits 2:0) and a sticky wrap flag (`full`, bit 3). A three-state machine follows how full the ring is. ST_EMPTY means nothing has been captured. ST_PARTIAL means records exist but the pointer has not yet passed from the last entry to the first. ST_WRAPPED means it has, and the pointer then names the oldest record. The transitions are as follows:
- T_FIRST_CAPTURE: EMPTY to PARTIAL.
- T_FIRST_WRAP: EMPTY or PARTIAL to WRAPPED, taken by a capture that crosses the end of the ring.
- T_SW_LOAD: any state to the state implied by a software-loaded pointer and flag.

A software port reads and writes entries and the pointer register. The block also reports the position of the newest record.

Top module: `btrace_recorder`

## Requirements
- R1: After reset every entry reads as zero (the invalid encoding b=0, mp=0), the pointer register reads zero, and `last_valid` is 0.
- R2: A source record has bit 0 (b) = 1, bit 1 (mp) = the mispredict flag, bits 3:2 = the slot index (0..2) when taken or 3 when not taken, and bits 63:4 = the source bundle address. It is written at position `bbi`.
- R3: A plain target record goes to position `bbi`+1 (mod 8). It has b=0, mp=1, slot=0 and the target bundle address in bits 63:4.
- R4: On capture, record bits 60:51 are each written with the value of record bit 50. A software entry write stores all 64 bits exactly as given.
- R5: `bbi` advances by the number of records a capture writes (mod 8), and old records are overwritten in ring order.
- R6: `full` (pointer register bit 3) is set when a capture writes past position 7 into position 0. It stays set until software writes the pointer register, which loads `bbi` from bits 2:0 and `full` from bit 3.
- R7: Merged mode (MERGE_TGT=1): when the target bundle holds a branch, position `bbi`+1 gets a source record built from the target address and the target branch's slot, taken and mispredict inputs. Two records are written.
- R8: Split mode (MERGE_TGT=0): when the target bundle holds a branch, a plain target record goes to `bbi`+1 and a source record for the target bundle goes to `bbi`+2. Three records are written.
- R9: While `freeze` is 1, retire strobes change no entry and neither pointer field.
- R10: Reads combinationally return the entry at `sw_addr` 0..7 while frozen and zero while running. `sw_addr` 8 returns {60'b0, full, bbi} at all times. Higher addresses return zero.
- R11: `last_idx` equals (`bbi` − 1) mod 8, and `last_valid` is 1 exactly when `full` or `bbi` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Stops capture and enables entry readback |
| ret_valid | input | 1 | Retire strobe for one qualified branch |
| ret_src_addr | input | 60 | Source bundle address |
| ret_src_slot | input | 2 | Slot of first taken branch in source bundle |
| ret_src_taken | input | 1 | Source branch taken |
| ret_src_mispred | input | 1 | Source branch mispredicted |
| ret_tgt_addr | input | 60 | Target bundle address |
| ret_tgt_is_br | input | 1 | Target bundle holds a qualified branch |
| ret_tgt_slot | input | 2 | Slot of that target branch |
| ret_tgt_taken | input | 1 | Target branch taken |
| ret_tgt_mispred | input | 1 | Target branch mispredicted |
| sw_en | input | 1 | Software access strobe |
| sw_we | input | 1 | Software write (with sw_en) |
| sw_addr | input | 4 | 0..7 entry, 8 pointer register |
| sw_wdata | input | 64 | Software write data |
| sw_rdata | output | 64 | Software read data |
| last_idx | output | 3 | Position of newest record |
| last_valid | output | 1 | At least one record captured |

## Verification
Both recording modes are built side by side and driven with the same stimulus. The sweep starts from every pointer position, set by a software load. It applies all eight combinations of taken, mispredict and target-holds-branch. This shows whether slot 3 replaces the slot on a not-taken branch, and whether mp follows the flag or is forced to 1 on target records. It also shows whether two or three records land, and whether they wrap at the correct position.

Source and target addresses alternate bit 50 of the record. This separates correct sign extension from copying the raw address. A software write with arbitrary upper bits then checks that the stored value is not extended. Frozen retires, running reads, out-of-range addresses and pointer loads, with and without the wrap flag, close the run.

// File: rtl/btrace_pkg.sv
package btrace_pkg;
    localparam int REC_W   = 64;
    localparam int ADDR_W  = 60;
    localparam int SEXT_LO = 51;
    localparam int SEXT_HI = 60;

    typedef logic [REC_W-1:0] rec_t;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_WRAPPED = 2'd2
    } ring_state_e;

    // Pack a record and replicate bit SEXT_LO-1 into the unimplemented span
    function automatic rec_t pack_rec(input logic [ADDR_W-1:0] addr,
                                      input logic [1:0] slot,
                                      input logic mp, input logic br);
        rec_t r;
        r = {addr, slot, mp, br};
        for (int i = SEXT_LO; i <= SEXT_HI; i++) r[i] = r[SEXT_LO-1];
        return r;
    endfunction
endpackage

// File: rtl/btrace_rec_fmt.sv
module btrace_rec_fmt
    import btrace_pkg::*;
#(
    parameter bit MERGE_TGT = 1'b1
) (
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [1:0]        src_slot,
    input  logic              src_taken,
    input  logic              src_mispred,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              tgt_is_br,
    input  logic [1:0]        tgt_slot,
    input  logic              tgt_taken,
    input  logic              tgt_mispred,
    output rec_t              rec0,
    output rec_t              rec1,
    output rec_t              rec2,
    output logic [1:0]        nrec
);
    logic [1:0] src_slot_enc;
    logic [1:0] tgt_slot_enc;
    rec_t       plain_tgt;
    rec_t       tgt_as_src;

    always_comb begin
        src_slot_enc = src_taken ? src_slot : 2'd3;
        tgt_slot_enc = tgt_taken ? tgt_slot : 2'd3;
        rec0         = pack_rec(src_addr, src_slot_enc, src_mispred, 1'b1);
        plain_tgt    = pack_rec(tgt_addr, 2'd0, 1'b1, 1'b0);
        tgt_as_src   = pack_rec(tgt_addr, tgt_slot_enc, tgt_mispred, 1'b1);
    end

    generate
        if (MERGE_TGT) begin : g_merge
            assign rec1 = tgt_is_br ? tgt_as_src : plain_tgt;
            assign rec2 = '0;
            assign nrec = 2'd2;
        end else begin : g_split
            assign rec1 = plain_tgt;
            assign rec2 = tgt_as_src;
            assign nrec = tgt_is_br ? 2'd3 : 2'd2;
        end
    endgenerate
endmodule

// File: rtl/btrace_index.sv
module btrace_index
    import btrace_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [1:0]       nrec,
    input  logic             ld,
    input  logic [IDX_W-1:0] ld_bbi,
    input  logic             ld_full,
    output logic [IDX_W-1:0] bbi,
    output logic             full,
    output logic             last_valid,
    output logic [IDX_W-1:0] last_idx
);
    ring_state_e      state_q, state_d;
    logic [IDX_W-1:0] bbi_q, bbi_d;
    logic [IDX_W+1:0] sum;
    logic             wrap;

    assign sum  = {2'b00, bbi_q} + {{IDX_W{1'b0}}, nrec};
    assign wrap = sum >= (IDX_W+2)'(ENTRIES);

    // Next-state and pointer logic
    always_comb begin
        state_d = state_q;
        bbi_d   = bbi_q;
        if (ld) begin
            bbi_d = ld_bbi;
            if (ld_full)            state_d = ST_WRAPPED;
            else if (ld_bbi == '0)  state_d = ST_EMPTY;
            else                    state_d = ST_PARTIAL;
        end else if (cap) begin
            bbi_d = sum[IDX_W-1:0];
            unique case (state_q)
                ST_EMPTY:   state_d = wrap ? ST_WRAPPED : ST_PARTIAL;
                ST_PARTIAL: state_d = wrap ? ST_WRAPPED : ST_PARTIAL;
                ST_WRAPPED: state_d = ST_WRAPPED;
                default:    state_d = ST_EMPTY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            bbi_q   <= '0;
        end else begin
            state_q <= state_d;
            bbi_q   <= bbi_d;
        end
    end

    // Outputs
    always_comb begin
        bbi        = bbi_q;
        full       = 1'b0;
        last_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY:   begin full = 1'b0; last_valid = 1'b0; end
            ST_PARTIAL: begin full = 1'b0; last_valid = 1'b1; end
            ST_WRAPPED: begin full = 1'b1; last_valid = 1'b1; end
            default:    begin full = 1'b0; last_valid = 1'b0; end
        endcase
        last_idx = bbi_q - IDX_W'(1);
    end
endmodule

// File: rtl/btrace_store.sv
module btrace_store
    import btrace_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int NWP     = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NWP-1:0]             cap_en,
    input  logic [NWP-1:0][IDX_W-1:0]  cap_idx,
    input  rec_t [NWP-1:0]             cap_data,
    input  logic                       sw_wr,
    input  logic [IDX_W-1:0]           sw_idx,
    input  rec_t                       sw_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output rec_t                       rd_data
);
    rec_t ent_arr [ENTRIES];

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
            rec_t ent_q;
            rec_t d;
            logic hit;

            // Capture ports take priority over a software write
            always_comb begin
                hit = sw_wr && (sw_idx == IDX_W'(e));
                d   = sw_data;
                for (int k = 0; k < NWP; k++) begin
                    if (cap_en[k] && cap_idx[k] == IDX_W'(e)) begin
                        hit = 1'b1;
                        d   = cap_data[k];
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n)   ent_q <= '0;
                else if (hit) ent_q <= d;
            end

            assign ent_arr[e] = ent_q;
        end
    endgenerate

    assign rd_data = ent_arr[rd_idx];
endmodule

// File: rtl/btrace_recorder.sv
module btrace_recorder
    import btrace_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter bit MERGE_TGT = 1'b1,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int SW_AW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              ret_valid,
    input  logic [59:0]       ret_src_addr,
    input  logic [1:0]        ret_src_slot,
    input  logic              ret_src_taken,
    input  logic              ret_src_mispred,
    input  logic [59:0]       ret_tgt_addr,
    input  logic              ret_tgt_is_br,
    input  logic [1:0]        ret_tgt_slot,
    input  logic              ret_tgt_taken,
    input  logic              ret_tgt_mispred,
    input  logic              sw_en,
    input  logic              sw_we,
    input  logic [SW_AW-1:0]  sw_addr,
    input  logic [63:0]       sw_wdata,
    output logic [63:0]       sw_rdata,
    output logic [IDX_W-1:0]  last_idx,
    output logic              last_valid
);
    localparam int NWP = 3;

    rec_t                      rec0, rec1, rec2;
    logic [1:0]                nrec;
    logic                      cap;
    logic [IDX_W-1:0]          bbi;
    logic                      full;
    logic                      idx_wr;
    logic                      ent_wr;
    logic                      ent_sel;
    logic [NWP-1:0]            cap_en;
    logic [NWP-1:0][IDX_W-1:0] cap_idx;
    rec_t [NWP-1:0]            cap_data;
    rec_t                      ent_rd;

    assign cap     = ret_valid && !freeze;
    assign ent_sel = sw_addr < SW_AW'(ENTRIES);
    assign idx_wr  = sw_en && sw_we && (sw_addr == SW_AW'(ENTRIES));
    assign ent_wr  = sw_en && sw_we && ent_sel;

    btrace_rec_fmt #(.MERGE_TGT(MERGE_TGT)) u_fmt (
        .src_addr    (ret_src_addr),
        .src_slot    (ret_src_slot),
        .src_taken   (ret_src_taken),
        .src_mispred (ret_src_mispred),
        .tgt_addr    (ret_tgt_addr),
        .tgt_is_br   (ret_tgt_is_br),
        .tgt_slot    (ret_tgt_slot),
        .tgt_taken   (ret_tgt_taken),
        .tgt_mispred (ret_tgt_mispred),
        .rec0        (rec0),
        .rec1        (rec1),
        .rec2        (rec2),
        .nrec        (nrec)
    );

    btrace_index #(.ENTRIES(ENTRIES)) u_idx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap        (cap),
        .nrec       (nrec),
        .ld         (idx_wr),
        .ld_bbi     (sw_wdata[IDX_W-1:0]),
        .ld_full    (sw_wdata[IDX_W]),
        .bbi        (bbi),
        .full       (full),
        .last_valid (last_valid),
        .last_idx   (last_idx)
    );

    always_comb begin
        cap_en      = {cap && (nrec == 2'd3), cap, cap};
        cap_idx[0]  = bbi;
        cap_idx[1]  = bbi + IDX_W'(1);
        cap_idx[2]  = bbi + IDX_W'(2);
        cap_data[0] = rec0;
        cap_data[1] = rec1;
        cap_data[2] = rec2;
    end

    btrace_store #(.ENTRIES(ENTRIES), .NWP(NWP)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_data (cap_data),
        .sw_wr    (ent_wr),
        .sw_idx   (sw_addr[IDX_W-1:0]),
        .sw_data  (sw_wdata),
        .rd_idx   (sw_addr[IDX_W-1:0]),
        .rd_data  (ent_rd)
    );

    always_comb begin
        sw_rdata = '0;
        if (ent_sel) begin
            if (freeze) sw_rdata = ent_rd;
        end else if (sw_addr == SW_AW'(ENTRIES)) begin
            sw_rdata = {{(64-IDX_W-1){1'b0}}, full, bbi};
        end
    end
endmodule

// File: rtl/btrace_checker.sv
module btrace_checker #(
    parameter int ENTRIES  = 8,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int SW_AW   = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             freeze,
    input logic             ret_valid,
    input logic             sw_en,
    input logic             sw_we,
    input logic [SW_AW-1:0] sw_addr,
    input logic [63:0]      sw_rdata,
    input logic [IDX_W-1:0] bbi,
    input logic             full,
    input logic [1:0]       nrec,
    input logic             last_valid
);
    logic             idx_wr;
    logic             cap;
    logic [IDX_W+1:0] sum;
    logic [IDX_W-1:0] exp_next;

    assign idx_wr   = sw_en && sw_we && (sw_addr == SW_AW'(ENTRIES));
    assign cap      = ret_valid && !freeze;
    assign sum      = {2'b00, bbi} + {{IDX_W{1'b0}}, nrec};
    assign exp_next = sum[IDX_W-1:0];

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !idx_wr) |=> (bbi == $past(exp_next))); // R5

    AST_WRAP_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !idx_wr && sum >= (IDX_W+2)'(ENTRIES)) |=> full); // R6

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !idx_wr) |=> full); // R6

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !idx_wr) |=> ($stable(bbi) && $stable(full))); // R9

    AST_RUN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && sw_addr < SW_AW'(ENTRIES)) |-> (sw_rdata == 64'd0)); // R10

    AST_EMPTY_CONSIST: assert property (@(posedge clk) disable iff (!rst_n)
        !last_valid |-> (bbi == '0 && !full)); // R11
endmodule

bind btrace_recorder btrace_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze     (freeze),
    .ret_valid  (ret_valid),
    .sw_en      (sw_en),
    .sw_we      (sw_we),
    .sw_addr    (sw_addr),
    .sw_rdata   (sw_rdata),
    .bbi        (bbi),
    .full       (full),
    .nrec       (nrec),
    .last_valid (last_valid)
);

// File: tb/btrace_recorder_bench.sv
`timescale 1ns/1ps
module btrace_recorder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0;
    logic        ret_valid = 1'b0;
    logic [59:0] ret_src_addr = '0;
    logic [1:0]  ret_src_slot = '0;
    logic        ret_src_taken = 1'b0;
    logic        ret_src_mispred = 1'b0;
    logic [59:0] ret_tgt_addr = '0;
    logic        ret_tgt_is_br = 1'b0;
    logic [1:0]  ret_tgt_slot = '0;
    logic        ret_tgt_taken = 1'b0;
    logic        ret_tgt_mispred = 1'b0;
    logic        sw_en = 1'b0;
    logic        sw_we = 1'b0;
    logic [3:0]  sw_addr = '0;
    logic [63:0] sw_wdata = '0;
    logic [63:0] rd [2];
    logic [2:0]  lidx [2];
    logic        lval [2];

    int errors = 0;
    int checks = 0;

    // Model state: index 0 = merged build, 1 = split build
    logic [63:0] exp_mem [2][8];
    logic [2:0]  exp_bbi [2];
    logic        exp_full [2];

    always #2 clk = ~clk;

    btrace_recorder #(.ENTRIES(8), .MERGE_TGT(1'b1)) u_btrace_recorder (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .ret_valid(ret_valid),
        .ret_src_addr(ret_src_addr), .ret_src_slot(ret_src_slot),
        .ret_src_taken(ret_src_taken), .ret_src_mispred(ret_src_mispred),
        .ret_tgt_addr(ret_tgt_addr), .ret_tgt_is_br(ret_tgt_is_br),
        .ret_tgt_slot(ret_tgt_slot), .ret_tgt_taken(ret_tgt_taken),
        .ret_tgt_mispred(ret_tgt_mispred), .sw_en(sw_en), .sw_we(sw_we),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(rd[0]),
        .last_idx(lidx[0]), .last_valid(lval[0]));

    btrace_recorder #(.ENTRIES(8), .MERGE_TGT(1'b0)) u_btrace_recorder_split (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .ret_valid(ret_valid),
        .ret_src_addr(ret_src_addr), .ret_src_slot(ret_src_slot),
        .ret_src_taken(ret_src_taken), .ret_src_mispred(ret_src_mispred),
        .ret_tgt_addr(ret_tgt_addr), .ret_tgt_is_br(ret_tgt_is_br),
        .ret_tgt_slot(ret_tgt_slot), .ret_tgt_taken(ret_tgt_taken),
        .ret_tgt_mispred(ret_tgt_mispred), .sw_en(sw_en), .sw_we(sw_we),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(rd[1]),
        .last_idx(lidx[1]), .last_valid(lval[1]));

    function automatic logic [63:0] mk(input logic [59:0] a, input logic [1:0] s,
                                       input logic mp, input logic b);
        logic [63:0] r;
        r = {a, s, mp, b};
        r[60:51] = r[50] ? 10'h3FF : 10'h000;
        return r;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 8; e++) exp_mem[m][e] = '0;
            exp_bbi[m] = '0;
            exp_full[m] = 1'b0;
        end
    endtask

    task automatic sw_write(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        sw_en = 1'b1; sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_en = 1'b0; sw_we = 1'b0;
        for (int m = 0; m < 2; m++) begin
            if (a < 4'd8) exp_mem[m][a[2:0]] = d;
            else if (a == 4'd8) begin
                exp_bbi[m] = d[2:0];
                exp_full[m] = d[3];
            end
        end
    endtask

    task automatic retire(input logic [59:0] sa, input logic [1:0] ss, input logic st,
                          input logic smp, input logic [59:0] ta, input logic tb,
                          input logic [1:0] ts, input logic tt, input logic tmp);
        logic [63:0] r [3];
        int n;
        @(negedge clk);
        ret_valid = 1'b1;
        ret_src_addr = sa; ret_src_slot = ss; ret_src_taken = st; ret_src_mispred = smp;
        ret_tgt_addr = ta; ret_tgt_is_br = tb; ret_tgt_slot = ts;
        ret_tgt_taken = tt; ret_tgt_mispred = tmp;
        @(negedge clk);
        ret_valid = 1'b0;
        if (!freeze) begin
            for (int m = 0; m < 2; m++) begin
                r[0] = mk(sa, st ? ss : 2'd3, smp, 1'b1);
                r[1] = mk(ta, 2'd0, 1'b1, 1'b0);
                r[2] = mk(ta, tt ? ts : 2'd3, tmp, 1'b1);
                n = 2;
                if (tb && m == 0) r[1] = r[2];
                if (tb && m == 1) n = 3;
                for (int k = 0; k < n; k++) exp_mem[m][(int'(exp_bbi[m]) + k) % 8] = r[k];
                if (int'(exp_bbi[m]) + n >= 8) exp_full[m] = 1'b1;
                exp_bbi[m] = 3'((int'(exp_bbi[m]) + n) % 8);
            end
        end
    endtask

    task automatic check_state(input string req);
        logic keep;
        keep = freeze;
        @(negedge clk);
        freeze = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 8; e++) begin
                sw_addr = 4'(e);
                #0.1;
                chk(rd[m], exp_mem[m][e], req);
            end
            sw_addr = 4'd8;
            #0.1;
            chk(rd[m], {60'd0, exp_full[m], exp_bbi[m]}, "R5 R6 R10 pointer");
            chk({63'd0, lval[m]}, {63'd0, exp_full[m] | (exp_bbi[m] != 3'd0)}, "R11 valid");
            if (exp_full[m] | (exp_bbi[m] != 3'd0))
                chk({61'd0, lidx[m]}, {61'd0, exp_bbi[m] - 3'd1}, "R11 last_idx");
        end
        freeze = keep;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_state("R1 reset");

        // Sweep every start position against every flag pattern
        for (int s = 0; s < 8; s++) begin
            sw_write(4'd8, {60'd0, 1'b0, 3'(s)});
            for (int p = 0; p < 8; p++) begin
                retire(60'h0AB_CDEF_0123_4567 ^ (60'(s) << 8) ^ (60'(p[0]) << 46),
                       2'(s % 3), p[0], p[1],
                       60'h051_2345_6789_ABCD ^ (60'(p) << 12) ^ (60'(p[1]) << 46),
                       p[2], 2'(p % 3), p[1], p[0]);
                check_state("R2 R3 R4 R5 R6 R7 R8 entries");
            end
        end

        // R9: frozen retire changes nothing
        freeze = 1'b1;
        retire(60'hFFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, 1'b1, 60'h123, 1'b1, 2'd2, 1'b1, 1'b1);
        check_state("R9 frozen retire");
        freeze = 1'b0;

        // R10: running reads of entries and out-of-range address return zero
        @(negedge clk);
        for (int e = 0; e < 8; e++) begin
            sw_addr = 4'(e);
            #0.1;
            chk(rd[0], 64'd0, "R10 running read");
        end
        sw_addr = 4'd9;
        #0.1;
        chk(rd[1], 64'd0, "R10 high address");

        // R4: software write keeps arbitrary upper bits
        sw_write(4'd3, 64'h1550_0000_0000_000C);
        check_state("R4 software entry");

        // R6: software load of pointer with and without the wrap flag
        sw_write(4'd8, 64'h0000_0000_0000_000D);
        check_state("R6 R11 load full");
        sw_write(4'd8, 64'h0000_0000_0000_0000);
        check_state("R6 clear full");
        retire(60'h000_0000_0000_0010, 2'd0, 1'b1, 1'b0, 60'h20, 1'b0, 2'd0, 1'b0, 1'b0);
        check_state("R2 R3 R5 after clear");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule